// File: doc/BRIEF.md
# Parallel L1 Distance Cell Array

This block holds a row of neuron cells. Each cell stores one training vector of byte components, a category label and a match threshold. Training is sequential. Bytes arrive one per write strobe and go into the cell chosen by an internal cell pointer, at successive component indices. A category strobe then closes the vector, stamps the cell as trained and moves the pointer on to the next cell. Once the last cell is trained, a full flag rises and later training strobes are dropped.

Recognition streams the test vector in the same way, one byte per strobe. Every trained cell reads its own stored component at the current index in the same cycle. It adds the absolute difference to a private running sum, so the cost of a recognition does not depend on how many cells are trained. A last-byte marker closes the stream. One cycle later, each cell presents its Manhattan distance, its category, a valid bit and a hit bit. The hit bit shows whether the distance is within that cell's threshold. Picking the winning cell is left to logic downstream.

Top module: `dist_cell_array`

## Requirements
- R1: After reset, `full` is 0, `res_strobe` is 0, every `cell_valid` and `cell_hit` bit is 0, every distance field is 0, and the first training vector goes to cell 0.
- R2: Each `lrn_wr` pulse stores `din` at the next component index of the selected cell, starting from index 0. After a category write the index starts again at 0.
- R3: A `lrn_cat_wr` pulse stores `cat_in` as the category of the selected cell, captures `thr_default` as that cell's threshold, marks the cell trained and advances the selection to the next cell in ascending order.
- R4: For every trained cell, the reported distance is the sum over all test bytes received of |test byte − stored byte at the same index|, using 8-bit unsigned components.
- R5: `res_strobe` pulses for exactly one cycle, on the clock edge after the edge that samples `rec_wr` with `rec_last` high. The per-cell outputs update on that same edge and hold until the next result.
- R6: A cell that is not trained reports valid 0, hit 0, distance 0 and category 0, and takes no part in recognition.
- R7: `cell_hit` for a trained cell is 1 exactly when its distance ≤ the threshold captured at its training. Later changes of `thr_default` do not affect trained cells.
- R8: Each recognition starts from a cleared sum, so the result of one test vector does not depend on earlier recognitions.
- R9: `full` rises after the category write of the last cell. While `full` is 1, `lrn_wr` and `lrn_cat_wr` have no effect on any stored vector, category or threshold.
- R10: The distance field is 8 + log2(VEC_LEN) bits wide. The largest sum, VEC_LEN × 255, is reported exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lrn_wr | input | 1 | Store `din` as next training component |
| lrn_cat_wr | input | 1 | Store `cat_in`, close the training vector |
| rec_wr | input | 1 | `din` is the next test component |
| rec_last | input | 1 | With `rec_wr`: this is the final test component |
| din | input | 8 | Component byte |
| cat_in | input | CAT_W | Category for training |
| thr_default | input | DIST_W | Threshold captured by a cell at its category write |
| cell_dist | output | NUM_CELLS*DIST_W | Per-cell distance, cell i at bits [i*DIST_W +: DIST_W] |
| cell_cat | output | NUM_CELLS*CAT_W | Per-cell category, cell i at bits [i*CAT_W +: CAT_W] |
| cell_valid | output | NUM_CELLS | Cell i was trained when the result was formed |
| cell_hit | output | NUM_CELLS | Cell i distance within its threshold |
| res_strobe | output | 1 | One-cycle pulse: new result set present |
| full | output | 1 | All cells trained |

## Verification
A test byte sampled at edge k reaches the stored-component read register at edge k, and the sum at edge k+1. The result fields and `res_strobe` therefore change on the edge after the one that sampled the last byte. The bench drives inputs on falling edges. It checks that `res_strobe` is still low half a cycle after the last byte is taken. It then reads every result field at the falling edge one full cycle later. Training writes take effect on the sampling edge, but they are only observed through a later recognition, so no separate latency is needed for them.

// File: rtl/dca_pkg.sv
package dca_pkg;

  localparam int COMP_W = 8;

  typedef logic [COMP_W-1:0] comp_t;

  // magnitude of the difference of two components, no multiplier involved
  function automatic comp_t comp_absdiff(input comp_t a, input comp_t b);
    return (a > b) ? comp_t'(a - b) : comp_t'(b - a);
  endfunction

endpackage

// File: rtl/dca_sched.sv
module dca_sched #(
  parameter int NUM_CELLS = 4,
  parameter int VEC_LEN   = 8,
  localparam int PTR_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
  localparam int AW    = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lrn_wr,
  input  logic                 lrn_cat_wr,
  input  logic                 rec_wr,
  input  logic                 rec_last,
  input  dca_pkg::comp_t       din,
  output logic [AW-1:0]        comp_ptr,
  output logic [NUM_CELLS-1:0] wr_sel,
  output logic [NUM_CELLS-1:0] cat_sel,
  output logic                 s1_valid,
  output logic                 s1_last,
  output logic                 s1_first,
  output dca_pkg::comp_t       s1_din,
  output logic                 res_strobe,
  output logic                 full
);

  logic [PTR_W-1:0] cell_ptr;
  logic             lrn_ok;
  logic             cat_ok;
  logic             ptr_at_end;

  assign lrn_ok     = lrn_wr && !full;
  assign cat_ok     = lrn_cat_wr && !full;
  assign ptr_at_end = (comp_ptr == AW'(VEC_LEN - 1));

  // one-hot steering of training strobes into the selected cell
  always_comb begin
    for (int i = 0; i < NUM_CELLS; i++) begin
      wr_sel[i]  = lrn_ok && (cell_ptr == PTR_W'(i));
      cat_sel[i] = cat_ok && (cell_ptr == PTR_W'(i));
    end
  end

  // component index: shared by training and recognition
  always_ff @(posedge clk) begin
    if (rst) begin
      comp_ptr <= '0;
    end else if (cat_ok) begin
      comp_ptr <= '0;
    end else if (rec_wr && rec_last) begin
      comp_ptr <= '0;
    end else if (lrn_ok || rec_wr) begin
      comp_ptr <= ptr_at_end ? '0 : comp_ptr + AW'(1);
    end
  end

  // cell selection and fill state
  always_ff @(posedge clk) begin
    if (rst) begin
      cell_ptr <= '0;
      full     <= 1'b0;
    end else if (cat_ok) begin
      if (cell_ptr == PTR_W'(NUM_CELLS - 1)) begin
        full <= 1'b1;
      end else begin
        cell_ptr <= cell_ptr + PTR_W'(1);
      end
    end
  end

  // stage 1 of recognition: aligns the test byte with the registered memory read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_last    <= 1'b0;
      s1_first   <= 1'b0;
      s1_din     <= '0;
      res_strobe <= 1'b0;
    end else begin
      s1_valid   <= rec_wr;
      s1_last    <= rec_wr && rec_last;
      s1_first   <= rec_wr && (comp_ptr == '0);
      s1_din     <= din;
      res_strobe <= s1_valid && s1_last;
    end
  end

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    full |=> (full && $stable(cell_ptr)));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cat_ok && cell_ptr != PTR_W'(NUM_CELLS - 1)) |=>
      (cell_ptr == PTR_W'($past(cell_ptr) + PTR_W'(1))));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_wr && rec_last) |=> (comp_ptr == '0));

  // R5
  strobe_lat_chk: assert property (@(posedge clk) disable iff (rst)
    res_strobe |-> $past(rec_wr && rec_last, 2));

endmodule

// File: rtl/dca_cell.sv
module dca_cell #(
  parameter int VEC_LEN = 8,
  parameter int CAT_W   = 8,
  localparam int AW     = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1,
  localparam int DIST_W = dca_pkg::COMP_W + $clog2(VEC_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              cat_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  dca_pkg::comp_t    din,
  input  logic [CAT_W-1:0]  cat_in,
  input  logic [DIST_W-1:0] thr_in,
  input  logic              s1_valid,
  input  logic              s1_last,
  input  logic              s1_first,
  input  dca_pkg::comp_t    s1_din,
  output logic [DIST_W-1:0] out_dist,
  output logic [CAT_W-1:0]  out_cat,
  output logic              out_valid,
  output logic              out_hit
);
  import dca_pkg::*;

  comp_t             vmem [VEC_LEN];
  comp_t             rd_q;
  logic [CAT_W-1:0]  cat_q;
  logic [DIST_W-1:0] thr_q;
  logic              trained;
  logic [DIST_W-1:0] acc;
  comp_t             diff;
  logic [DIST_W:0]   sum_wide;
  logic [DIST_W-1:0] sum;

  // vector store: single write port, registered read, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vmem[addr] <= din;
    end
    if (rd_en) begin
      rd_q <= vmem[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trained <= 1'b0;
      cat_q   <= '0;
      thr_q   <= '0;
    end else if (cat_en) begin
      trained <= 1'b1;
      cat_q   <= cat_in;
      thr_q   <= thr_in;
    end
  end

  assign diff     = comp_absdiff(s1_din, rd_q);
  assign sum_wide = s1_first ? {{(DIST_W + 1 - COMP_W){1'b0}}, diff}
                             : {1'b0, acc} + {{(DIST_W + 1 - COMP_W){1'b0}}, diff};
  assign sum      = sum_wide[DIST_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (s1_valid && trained) begin
      acc <= sum;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_dist  <= '0;
      out_cat   <= '0;
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
    end else if (s1_valid && s1_last) begin
      out_dist  <= trained ? sum : '0;
      out_cat   <= trained ? cat_q : '0;
      out_valid <= trained;
      out_hit   <= trained && (sum <= thr_q);
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && trained) |-> !sum_wide[DIST_W]);

  // R6
  untrained_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !trained |-> (!out_valid && !out_hit && out_dist == '0));

  // R7
  hit_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> out_valid);

endmodule

// File: rtl/dist_cell_array.sv
module dist_cell_array #(
  parameter int NUM_CELLS = 4,
  parameter int VEC_LEN   = 8,
  parameter int CAT_W     = 8,
  localparam int DIST_W   = dca_pkg::COMP_W + $clog2(VEC_LEN)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        lrn_wr,
  input  logic                        lrn_cat_wr,
  input  logic                        rec_wr,
  input  logic                        rec_last,
  input  logic [7:0]                  din,
  input  logic [CAT_W-1:0]            cat_in,
  input  logic [DIST_W-1:0]           thr_default,
  output logic [NUM_CELLS*DIST_W-1:0] cell_dist,
  output logic [NUM_CELLS*CAT_W-1:0]  cell_cat,
  output logic [NUM_CELLS-1:0]        cell_valid,
  output logic [NUM_CELLS-1:0]        cell_hit,
  output logic                        res_strobe,
  output logic                        full
);
  localparam int AW = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1;

  logic [AW-1:0]        comp_ptr;
  logic [NUM_CELLS-1:0] wr_sel;
  logic [NUM_CELLS-1:0] cat_sel;
  logic                 s1_valid;
  logic                 s1_last;
  logic                 s1_first;
  dca_pkg::comp_t       s1_din;

  dca_sched #(
    .NUM_CELLS (NUM_CELLS),
    .VEC_LEN   (VEC_LEN)
  ) u_sched (
    .clk        (clk),
    .rst        (rst),
    .lrn_wr     (lrn_wr),
    .lrn_cat_wr (lrn_cat_wr),
    .rec_wr     (rec_wr),
    .rec_last   (rec_last),
    .din        (din),
    .comp_ptr   (comp_ptr),
    .wr_sel     (wr_sel),
    .cat_sel    (cat_sel),
    .s1_valid   (s1_valid),
    .s1_last    (s1_last),
    .s1_first   (s1_first),
    .s1_din     (s1_din),
    .res_strobe (res_strobe),
    .full       (full)
  );

  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
    dca_cell #(
      .VEC_LEN (VEC_LEN),
      .CAT_W   (CAT_W)
    ) u_cell (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_sel[g]),
      .cat_en    (cat_sel[g]),
      .rd_en     (rec_wr),
      .addr      (comp_ptr),
      .din       (din),
      .cat_in    (cat_in),
      .thr_in    (thr_default),
      .s1_valid  (s1_valid),
      .s1_last   (s1_last),
      .s1_first  (s1_first),
      .s1_din    (s1_din),
      .out_dist  (cell_dist[g*DIST_W +: DIST_W]),
      .out_cat   (cell_cat[g*CAT_W +: CAT_W]),
      .out_valid (cell_valid[g]),
      .out_hit   (cell_hit[g])
    );
  end

  // R1
  full_rst_chk: assert property (@(posedge clk)
    $past(rst) |-> (!full && !res_strobe && cell_valid == '0));

endmodule

// File: tb/dist_cell_array_bench.sv
module dist_cell_array_bench;
  localparam int NC = 4;
  localparam int VL = 8;
  localparam int CW = 8;
  localparam int DW = 8 + $clog2(VL);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lrn_wr = 1'b0, lrn_cat_wr = 1'b0, rec_wr = 1'b0, rec_last = 1'b0;
  logic [7:0] din = '0;
  logic [CW-1:0] cat_in = '0;
  logic [DW-1:0] thr_default = '0;
  logic [NC*DW-1:0] cell_dist;
  logic [NC*CW-1:0] cell_cat;
  logic [NC-1:0] cell_valid, cell_hit;
  logic res_strobe, full;

  always #2 clk = ~clk;

  dist_cell_array #(.NUM_CELLS(NC), .VEC_LEN(VL), .CAT_W(CW)) u_dist_cell_array (
    .clk(clk), .rst(rst), .lrn_wr(lrn_wr), .lrn_cat_wr(lrn_cat_wr),
    .rec_wr(rec_wr), .rec_last(rec_last), .din(din), .cat_in(cat_in),
    .thr_default(thr_default), .cell_dist(cell_dist), .cell_cat(cell_cat),
    .cell_valid(cell_valid), .cell_hit(cell_hit), .res_strobe(res_strobe), .full(full));

  int checks = 0;
  int fails = 0;

  // reference model
  logic [7:0]    mvec [NC][VL];
  logic [CW-1:0] mcat [NC];
  logic [DW-1:0] mthr [NC];
  logic          mtr  [NC];
  int            mptr = 0;
  logic [7:0]    lv [VL];
  logic [7:0]    tv [VL];

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model_dist(input int c);
    int s = 0;
    for (int k = 0; k < VL; k++)
      s += (tv[k] > mvec[c][k]) ? int'(tv[k]) - int'(mvec[c][k]) : int'(mvec[c][k]) - int'(tv[k]);
    return s;
  endfunction

  // R2 R3 R9: stream lv then a category; model follows only while not full
  task automatic learn(input logic [CW-1:0] cat);
    for (int k = 0; k < VL; k++) begin
      @(negedge clk); lrn_wr = 1'b1; din = lv[k];
    end
    @(negedge clk); lrn_wr = 1'b0; lrn_cat_wr = 1'b1; cat_in = cat;
    @(negedge clk); lrn_cat_wr = 1'b0;
    if (mptr < NC) begin
      for (int k = 0; k < VL; k++) mvec[mptr][k] = lv[k];
      mcat[mptr] = cat; mthr[mptr] = thr_default; mtr[mptr] = 1'b1;
      mptr++;
    end
  endtask

  // R4 R5 R6 R7: stream tv, check strobe timing and every cell's result
  task automatic recognize(input string tag);
    int d;
    for (int k = 0; k < VL; k++) begin
      @(negedge clk); rec_wr = 1'b1; din = tv[k]; rec_last = (k == VL - 1);
    end
    @(negedge clk); rec_wr = 1'b0; rec_last = 1'b0;
    check("R5", {tag, " strobe early"}, int'(res_strobe), 0);
    @(negedge clk);
    check("R5", {tag, " strobe due"}, int'(res_strobe), 1);
    for (int c = 0; c < NC; c++) begin
      d = mtr[c] ? model_dist(c) : 0;
      check(mtr[c] ? "R4" : "R6", $sformatf("%s dist[%0d]", tag, c), int'(cell_dist[c*DW +: DW]), d);
      check(mtr[c] ? "R3" : "R6", $sformatf("%s cat[%0d]", tag, c), int'(cell_cat[c*CW +: CW]), mtr[c] ? int'(mcat[c]) : 0);
      check("R6", $sformatf("%s valid[%0d]", tag, c), int'(cell_valid[c]), int'(mtr[c]));
      check("R7", $sformatf("%s hit[%0d]", tag, c), int'(cell_hit[c]), int'(mtr[c] && d <= int'(mthr[c])));
    end
    @(negedge clk);
    check("R5", {tag, " strobe single"}, int'(res_strobe), 0);
  endtask

  task automatic t_reset;
    check("R1", "full", int'(full), 0);
    check("R1", "strobe", int'(res_strobe), 0);
    check("R1", "valid", int'(cell_valid), 0);
    check("R1", "hit", int'(cell_hit), 0);
    check("R1", "dist", int'(cell_dist == '0), 1);
  endtask

  task automatic t_train_two;
    thr_default = DW'(100);
    for (int k = 0; k < VL; k++) lv[k] = 8'(10 + 10 * k);
    learn(8'd5);
    thr_default = DW'(20);
    for (int k = 0; k < VL; k++) lv[k] = 8'(200 - 10 * k);
    learn(8'd9);
    check("R9", "not full after two", int'(full), 0);
  endtask

  task automatic t_recog_pair;
    for (int k = 0; k < VL; k++) tv[k] = 8'(12 + 10 * k - 3 * (k % 2));
    recognize("R1first");
    for (int k = 0; k < VL; k++) tv[k] = 8'(195 - 9 * k);
    recognize("R8second");
  endtask

  task automatic t_thr_isolation;
    thr_default = DW'(2047);
    for (int k = 0; k < VL; k++) tv[k] = 8'(12 + 10 * k);
    recognize("R7thr");
  endtask

  task automatic t_fill_and_ignore;
    for (int k = 0; k < VL; k++) lv[k] = 8'(30 * k);
    learn(8'd3);
    check("R9", "not full after three", int'(full), 0);
    for (int k = 0; k < VL; k++) lv[k] = 8'd0;
    learn(8'd7);
    check("R9", "full after four", int'(full), 1);
    for (int k = 0; k < VL; k++) lv[k] = 8'hFF;
    thr_default = DW'(0);
    learn(8'd77);
    check("R9", "full holds", int'(full), 1);
    for (int k = 0; k < VL; k++) tv[k] = 8'hFF;
    recognize("R9R10max");
    check("R10", "max dist cell3", int'(cell_dist[3*DW +: DW]), VL * 255);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) mtr[c] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_train_two();
    t_recog_pair();
    t_thr_isolation();
    t_fill_and_ignore();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule